// File: doc/BRIEF.md
# Bus-Driven SPI Configuration Bridge

This block lives in the programmable logic of a peripheral card on an 8-bit microprocessor expansion bus. It gives host software a bit-by-bit path to a hard SPI configuration port. The active-low device-select strobe of the card's 16-byte device window drives the SPI clock, and address bit 0 drives the SPI data-in. Each CPU read of one of two adjacent window addresses therefore clocks one bit into the port. The even address sends a 0 and the odd address sends a 1.

The SPI chip select is normally left at high impedance, and a board pull-up keeps it high. Software unlocks the link by writing a fixed value to a fixed window offset. The block then drives chip select low. While the link is unlocked, a read at either shift address returns the SPI data-out bit in data bit 7, with all lower bits zero. Every other read returns the normal register byte unchanged. The block also produces the enable for the data-bus transceiver during window reads.

The strobe, the data-out pin and the bus reset are asynchronous to the system clock. The strobe and data-out are brought in through synchroniser chains. The read/write direction and the offset are latched when the strobe falls. The data-out bit is latched at the same edge, so a read returns one stable bit for its whole length. None of the data here flows as a stream, so every pin is a plain level without a valid/ready handshake.

Top module: `spi_cfg_bridge`

## Requirements
- R1: After reset (`rst_n` low), `spi_cs_oe` is 0 (chip select at high impedance) and `xcvr_oe` is 0. A reset at any later time also returns `spi_cs_oe` to 0.
- R2: A write cycle (`bus_rd`=0) at window offset 0x5 with write data 0xA5 sets `spi_cs_oe` to 1 by the end of that strobe.
- R3: A write at offset 0x5 with any other data clears `spi_cs_oe` to 0. A write of any value at any other offset leaves `spi_cs_oe` unchanged.
- R4: `spi_clk` always equals `dev_sel_n`, and `spi_di` always equals `bus_addr[0]`.
- R5: While `spi_cs_oe` is 1, a read at offset 0xA or 0xB returns `bus_rdata` = {latched data-out bit, 7'b0}.
- R6: While `spi_cs_oe` is 0, reads at offsets 0xA and 0xB return `reg_rdata` unchanged.
- R7: Reads at offsets other than 0xA and 0xB return `reg_rdata` unchanged, whatever the link state.
- R8: `xcvr_oe` is 1 during read cycles of the window and 0 during write cycles and between cycles.
- R9: The returned data-out bit is the value of `spi_do` when the strobe fell. Later changes of `spi_do` within the same cycle do not change `bus_rdata`.
- R10: The offset and the direction are taken when the strobe falls. An address change later within the cycle does not change the substitution decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous assertion |
| dev_sel_n | input | 1 | Device-window strobe, active low, asynchronous |
| bus_addr | input | 4 | Offset within the device window |
| bus_rd | input | 1 | 1 = CPU read, 0 = CPU write |
| bus_wdata | input | 8 | Write data from the CPU |
| reg_rdata | input | 8 | Normal register data of the card for the current offset |
| spi_do | input | 1 | Data-out pin of the SPI configuration port, asynchronous |
| bus_rdata | output | 8 | Byte returned to the CPU |
| xcvr_oe | output | 1 | Data-bus transceiver enable, active high |
| spi_cs_oe | output | 1 | 1 drives chip select low; 0 leaves it at high impedance |
| spi_clk | output | 1 | SPI clock (the device-select strobe) |
| spi_di | output | 1 | SPI data-in (address bit 0) |

## Verification
The bench uses the default parameters: a two-stage synchroniser, unlock offset 0x5, unlock value 0xA5 and shift pair 0xA/0xB. With the two-stage chain, the effect of a strobe edge on the outputs lands a fixed three clock edges later. This lets the bench check the read byte and the transceiver enable mid-cycle, and the chip-select state after each cycle. The unlock value and offset choices let near-miss writes be tested against the real unlock: the right value at a wrong offset, and a one-bit-off value at the right offset. The shift pair sits beside ordinary offsets, so both bypass conditions can be shown: a locked link and an unselected address.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int unsigned OFS_W  = 4;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic             rd;
  } bus_cycle_t;
endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_bridge_cycle.sv
module spi_bridge_cycle
  import spi_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_s,
  input  logic [OFS_W-1:0] addr,
  input  logic             rd,
  input  logic             do_s,
  output logic             fall,
  output logic             rise,
  output logic             active,
  output bus_cycle_t       cyc,
  output logic             do_lat
);
  logic sel_prev;

  assign fall = sel_prev & ~sel_n_s;
  assign rise = ~sel_prev & sel_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 1'b1;
      active   <= 1'b0;
      cyc      <= '0;
      do_lat   <= 1'b0;
    end else begin
      sel_prev <= sel_n_s;
      if (fall) begin
        active  <= 1'b1;
        cyc.ofs <= addr;
        cyc.rd  <= rd;
        do_lat  <= do_s;
      end else if (rise) begin
        active  <= 1'b0;
      end
    end
  end

  AST_CYC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (active && !fall) |=> $stable(cyc)) else $error("cycle fields moved"); // R10
  AST_DO_HELD: assert property (@(posedge clk) disable iff (!rst_n) (active && !fall) |=> $stable(do_lat)) else $error("data-out latch moved"); // R9
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fall && rise)) else $error("both edges"); // R10
endmodule

// File: rtl/spi_bridge_unlock.sv
module spi_bridge_unlock
  import spi_bridge_pkg::*;
#(
  parameter logic [OFS_W-1:0]  UNLOCK_OFS = 4'h5,
  parameter logic [BYTE_W-1:0] UNLOCK_VAL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  bus_cycle_t        cyc,
  input  logic [BYTE_W-1:0] wdata,
  output logic              link_en
);
  logic hit;
  assign hit = rise && !cyc.rd && (cyc.ofs == UNLOCK_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   link_en <= 1'b0;
    else if (hit) link_en <= (wdata == UNLOCK_VAL);
  end

  AST_LINK_STILL: assert property (@(posedge clk) disable iff (!rst_n) !rise |=> $stable(link_en)) else $error("link changed off-edge"); // R3
  AST_READ_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n) (rise && cyc.rd) |=> $stable(link_en)) else $error("read changed link"); // R3
endmodule

// File: rtl/spi_cfg_bridge.sv
module spi_cfg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [OFS_W-1:0]   UNLOCK_OFS  = 4'h5,
  parameter logic [BYTE_W-1:0]  UNLOCK_VAL  = 8'hA5,
  parameter logic [OFS_W-1:0]   SHIFT_BASE  = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel_n,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              spi_do,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              xcvr_oe,
  output logic              spi_cs_oe,
  output logic              spi_clk,
  output logic              spi_di
);
  localparam int unsigned REPLY_BIT = BYTE_W - 1;

  logic       sel_n_s, do_s, fall, rise, active, do_lat, link_en, sub_sel;
  bus_cycle_t cyc;

  assign spi_clk = dev_sel_n;
  assign spi_di  = bus_addr[0];

  spi_bridge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d_in(dev_sel_n), .d_sync(sel_n_s));

  spi_bridge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_do_sync (
    .clk(clk), .rst_n(rst_n), .d_in(spi_do), .d_sync(do_s));

  spi_bridge_cycle u_cycle (
    .clk(clk), .rst_n(rst_n), .sel_n_s(sel_n_s), .addr(bus_addr), .rd(bus_rd),
    .do_s(do_s), .fall(fall), .rise(rise), .active(active), .cyc(cyc), .do_lat(do_lat));

  spi_bridge_unlock #(.UNLOCK_OFS(UNLOCK_OFS), .UNLOCK_VAL(UNLOCK_VAL)) u_unlock (
    .clk(clk), .rst_n(rst_n), .rise(rise), .cyc(cyc), .wdata(bus_wdata), .link_en(link_en));

  assign spi_cs_oe = link_en;
  assign xcvr_oe   = active & cyc.rd;
  assign sub_sel   = link_en & cyc.rd & (cyc.ofs[OFS_W-1:1] == SHIFT_BASE[OFS_W-1:1]);

  always_comb begin
    if (sub_sel) begin
      bus_rdata            = '0;
      bus_rdata[REPLY_BIT] = do_lat;
    end else begin
      bus_rdata            = reg_rdata;
    end
  end

  AST_SUB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (spi_cs_oe && xcvr_oe && cyc.ofs[OFS_W-1:1] == SHIFT_BASE[OFS_W-1:1]) |-> (bus_rdata[REPLY_BIT-1:0] == '0)) else $error("low bits not zero"); // R5
  AST_PASS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_oe |-> (bus_rdata == reg_rdata)) else $error("locked read altered"); // R6
  AST_XCVR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (rise && !fall) |=> !xcvr_oe) else $error("transceiver left on"); // R8
  AST_XCVR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (active && !cyc.rd) |-> !xcvr_oe) else $error("transceiver on in write"); // R8
endmodule

// File: tb/spi_cfg_bridge_bench.sv
module spi_cfg_bridge_bench;
  logic       clk = 1'b0, rst_n = 1'b0, dev_sel_n = 1'b1, bus_rd = 1'b1, spi_do = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, reg_rdata = '0, bus_rdata;
  logic       xcvr_oe, spi_cs_oe, spi_clk, spi_di;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  spi_cfg_bridge u_spi_cfg_bridge (
    .clk(clk), .rst_n(rst_n), .dev_sel_n(dev_sel_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .reg_rdata(reg_rdata), .spi_do(spi_do), .bus_rdata(bus_rdata),
    .xcvr_oe(xcvr_oe), .spi_cs_oe(spi_cs_oe), .spi_clk(spi_clk), .spi_di(spi_di));

  typedef struct packed {
    logic [3:0] ofs; logic rd; logic [7:0] wd; logic [7:0] rg; logic dout;
    logic [7:0] exp_rd; logic exp_cs; logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'hA, 1'b1, 8'h00, 8'h3C, 1'b1, 8'h3C, 1'b0, 4'd6},  // R6 locked
    '{4'h5, 1'b0, 8'hA5, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 unlock
    '{4'hA, 1'b1, 8'h00, 8'h3C, 1'b1, 8'h80, 1'b1, 4'd5},  // R5 reply 1
    '{4'hB, 1'b1, 8'h00, 8'h11, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 reply 0
    '{4'h3, 1'b1, 8'h00, 8'h5A, 1'b1, 8'h5A, 1'b1, 4'd7},  // R7 other offset
    '{4'h6, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 other offset write
    '{4'h5, 1'b0, 8'hA4, 8'h00, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 relock
    '{4'hB, 1'b1, 8'h00, 8'h77, 1'b1, 8'h77, 1'b0, 4'd6},  // R6 locked odd
    '{4'h7, 1'b0, 8'hA5, 8'h00, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 value at wrong offset
    '{4'h5, 1'b0, 8'hA5, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 unlock again
    '{4'hB, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h80, 1'b1, 4'd5}   // R5 low bits cleared
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_cycle(input logic [3:0] ofs, input logic rd, input logic [7:0] wd,
                            input logic [7:0] rg, input logic dout);
    bus_addr = ofs; bus_rd = rd; bus_wdata = wd; reg_rdata = rg; spi_do = dout;
    step(4);
    dev_sel_n = 1'b0;
    step(5);
  endtask

  task automatic close_cycle();
    dev_sel_n = 1'b1;
    step(5);
  endtask

  initial begin
    step(3);
    check(1, {spi_cs_oe, xcvr_oe}, 2'b00);                    // R1 in reset
    rst_n = 1'b1;
    step(2);
    check(1, {spi_cs_oe, xcvr_oe}, 2'b00);                    // R1 after release

    for (int v = 0; v < NV; v++) begin
      open_cycle(VEC[v].ofs, VEC[v].rd, VEC[v].wd, VEC[v].rg, VEC[v].dout);
      check(8, xcvr_oe, VEC[v].rd);                           // R8
      check(4, {spi_clk, spi_di}, {1'b0, VEC[v].ofs[0]});     // R4
      if (VEC[v].rd) check(VEC[v].req, bus_rdata, VEC[v].exp_rd);
      close_cycle();
      check(8, xcvr_oe, 1'b0);                                // R8 idle
      check(VEC[v].req, spi_cs_oe, VEC[v].exp_cs);
    end
    check(4, {spi_clk, spi_di}, {dev_sel_n, bus_addr[0]});    // R4 idle

    // R9: data-out changes after the fall are not seen
    open_cycle(4'hA, 1'b1, 8'h00, 8'h00, 1'b0);
    spi_do = 1'b1; step(4);
    check(9, bus_rdata, 8'h00);
    close_cycle();

    // R10: address moves mid-cycle from shift address to plain one
    open_cycle(4'hB, 1'b1, 8'h00, 8'h42, 1'b1);
    bus_addr = 4'h2; step(4);
    check(10, bus_rdata, 8'h80);
    close_cycle();

    // R10: write at shift address is not a shift read even if bus_rd rises late
    open_cycle(4'hA, 1'b0, 8'h00, 8'h24, 1'b1);
    bus_rd = 1'b1; step(4);
    check(10, {xcvr_oe, bus_rdata}, {1'b0, 8'h24});
    close_cycle();

    // R1: reset while unlocked releases chip select
    check(1, spi_cs_oe, 1'b1);
    rst_n = 1'b0; step(2);
    check(1, {spi_cs_oe, xcvr_oe}, 2'b00);
    rst_n = 1'b1; step(2);
    check(1, spi_cs_oe, 1'b0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule